// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This controller drives the row-level strobes of a pixel array and walks one shared converter across the columns of each row. A frame starts when `start` is seen while the block is idle. The block then runs a series of row slots. In slot k it pulses the reset strobe for row k. It also holds the select line of row k−E while that row is converted. E is the exposure length in row slots, and it is captured at start. Because each row's reset is staggered one slot behind the previous row's, every row is integrated for the same number of slot boundaries. The rows therefore form a rolling shutter.

During a read slot the sequencer pulses `adc_start` once per column, from column 0 up to the last column of the group. It waits for `adc_done` before it advances. It forwards each returned code as a one-cycle pixel beat tagged with row and column. Slots that have no row to read, at the start of a frame, last a fixed number of padding cycles. The 2-bit pre-converter gain code is captured at start and held on `gain_out` for the whole frame. After the final conversion of the last row, a one-cycle `frame_done` pulse is raised and the block returns to idle.

Top module: `rs_row_sequencer`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `row_rst`, `row_sel`, `adc_start`, `pix_valid` and `frame_done` are low, and `col_idx` and `gain_out` are zero.
- R2: `start` is accepted only while idle. A `start` seen during a frame leaves that frame's exposure, gain and schedule unchanged.
- R3: The exposure `exp_rows` is captured at start. A value of 0 becomes 1, and a value above ROWS becomes ROWS.
- R4: Slots are numbered k = 0 .. ROWS−1+E. In slot k, a one-cycle `row_rst` pulse names row k when k < ROWS. When k ≥ E, `row_sel` rises in that same cycle and names row k−E. No reset pulse is issued in the slots k ≥ ROWS.
- R5: `row_sel` stays high with a constant `row_sel_idx` from the start of a read slot until that row's last conversion is returned.
- R6: `adc_start` is a one-cycle pulse that occurs only while `row_sel` is high. The n-th pulse of a row carries `col_idx` = n, for n = 0 .. GROUP−1.
- R7: `col_idx` changes during a read only in the cycle after `adc_done` was high. It holds for as long as the converter delays.
- R8: For each conversion, `pix_valid` is high for one cycle together with the code captured with `adc_done`, the row being read and the column converted.
- R9: Row j is selected only after all GROUP conversions of row j−1 have been returned. Rows are read in ascending order, ROWS rows per frame.
- R10: `gain_out` shows the captured `gain_code`, where 0, 1, 2 and 3 mean 1x, 2x, 3x and 4x. It holds for the whole frame.
- R11: `frame_done` pulses exactly once per frame, in the same cycle as the pixel beat of the last column of the last row.
- R12: A slot that has no row to read lasts PAD_CYC+1 cycles from its reset pulse to the next reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (idle only) |
| exp_rows | input | EXP_W | Exposure length in row slots |
| gain_code | input | 2 | Pre-converter gain code, 0..3 = 1x..4x |
| adc_done | input | 1 | Converter result ready |
| adc_code | input | CODE_W | Converter result |
| row_rst | output | 1 | One-cycle row reset strobe |
| row_rst_idx | output | ROW_W | Row being reset |
| row_sel | output | 1 | Row select level |
| row_sel_idx | output | ROW_W | Row being read |
| col_idx | output | COL_W | Column multiplexer position |
| gain_out | output | 2 | Gain code held for the frame |
| adc_start | output | 1 | One-cycle conversion request |
| pix_valid | output | 1 | Pixel beat strobe |
| pix_code | output | CODE_W | Pixel code |
| pix_row | output | ROW_W | Pixel row |
| pix_col | output | COL_W | Pixel column |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The hardest situation to reach from the ports is the overlap of a reset for row j+E with the read of row j. The overlap must also be shown to shift with the clamped exposure, including when the exposure input is out of range. A second hard case is a `start` that arrives mid-frame. The bench runs whole frames with exposure inputs of 0, in-range values and above ROWS. It models the converter with latencies from zero to twenty cycles. At every reset pulse it checks which row, if any, is selected at that moment. Two frames receive a second `start` with a different gain and exposure partway through, and the bench shows that the schedule and `gain_out` do not move.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEGIN = 3'd1,
        ST_START = 3'd2,
        ST_WAIT  = 3'd3,
        ST_PAD   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/rs_exp_clamp.sv
module rs_exp_clamp #(
    parameter int ROWS  = 1080,
    parameter int EXP_W = $clog2(ROWS + 1)
) (
    input  logic [EXP_W-1:0] raw_exp,
    output logic [EXP_W-1:0] safe_exp
);

    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(ROWS);
    localparam logic [EXP_W-1:0] EXP_MIN = EXP_W'(1);

    always_comb begin
        if (raw_exp == '0) begin
            safe_exp = EXP_MIN;
        end else if (raw_exp > EXP_MAX) begin
            safe_exp = EXP_MAX;
        end else begin
            safe_exp = raw_exp;
        end
    end

endmodule

// File: rtl/rs_slot_map.sv
module rs_slot_map #(
    parameter int ROWS   = 1080,
    parameter int EXP_W  = $clog2(ROWS + 1),
    parameter int SLOT_W = $clog2(2 * ROWS),
    parameter int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [EXP_W-1:0]  exp_len,
    output logic              rst_en,
    output logic [ROW_W-1:0]  rst_row,
    output logic              rd_en,
    output logic [ROW_W-1:0]  rd_row,
    output logic              last_slot
);

    localparam logic [SLOT_W-1:0] ROWS_S = SLOT_W'(ROWS);
    localparam logic [SLOT_W-1:0] LAST_R = SLOT_W'(ROWS - 1);

    logic [SLOT_W-1:0] exp_s;

    always_comb begin
        exp_s     = SLOT_W'(exp_len);
        rst_en    = (slot < ROWS_S);
        rst_row   = ROW_W'(slot);
        rd_en     = (slot >= exp_s);
        rd_row    = ROW_W'(slot - exp_s);
        last_slot = (slot == (LAST_R + exp_s));
    end

endmodule

// File: rtl/rs_col_step.sv
module rs_col_step #(
    parameter int GROUP = 16,
    parameter int COL_W = $clog2(GROUP)
) (
    input  logic [COL_W-1:0] col,
    output logic             col_last,
    output logic [COL_W-1:0] col_next
);

    localparam logic [COL_W-1:0] COL_END = COL_W'(GROUP - 1);

    always_comb begin
        col_last = (col == COL_END);
        col_next = col + COL_W'(1);
    end

endmodule

// File: rtl/rs_row_sequencer.sv
module rs_row_sequencer
    import rs_seq_pkg::*;
#(
    parameter int ROWS    = 1080,
    parameter int GROUP   = 16,
    parameter int CODE_W  = 12,
    parameter int PAD_CYC = 16,
    localparam int EXP_W  = $clog2(ROWS + 1),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W  = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [EXP_W-1:0]  exp_rows,
    input  logic [1:0]        gain_code,
    input  logic              adc_done,
    input  logic [CODE_W-1:0] adc_code,
    output logic              row_rst,
    output logic [ROW_W-1:0]  row_rst_idx,
    output logic              row_sel,
    output logic [ROW_W-1:0]  row_sel_idx,
    output logic [COL_W-1:0]  col_idx,
    output logic [1:0]        gain_out,
    output logic              adc_start,
    output logic              pix_valid,
    output logic [CODE_W-1:0] pix_code,
    output logic [ROW_W-1:0]  pix_row,
    output logic [COL_W-1:0]  pix_col,
    output logic              frame_done
);

    localparam int SLOT_W = $clog2(2 * ROWS);
    localparam int PAD_W  = (PAD_CYC > 1) ? $clog2(PAD_CYC) : 1;
    localparam logic [PAD_W-1:0] PAD_END = PAD_W'(PAD_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [EXP_W-1:0]  exp_len;
        logic [1:0]        gain;
        logic [COL_W-1:0]  col;
        logic [PAD_W-1:0]  pad;
        logic              rst_p;
        logic [ROW_W-1:0]  rst_row;
        logic              sel;
        logic [ROW_W-1:0]  sel_row;
        logic              adc_go;
        logic              pv;
        logic [CODE_W-1:0] code;
        logic [ROW_W-1:0]  prow;
        logic [COL_W-1:0]  pcol;
        logic              fdone;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [EXP_W-1:0] exp_safe;
    logic             map_rst_en;
    logic [ROW_W-1:0] map_rst_row;
    logic             map_rd_en;
    logic [ROW_W-1:0] map_rd_row;
    logic             map_last;
    logic             col_last;
    logic [COL_W-1:0] col_next;
    logic             end_slot;

    rs_exp_clamp #(
        .ROWS  (ROWS),
        .EXP_W (EXP_W)
    ) u_clamp (
        .raw_exp  (exp_rows),
        .safe_exp (exp_safe)
    );

    rs_slot_map #(
        .ROWS   (ROWS),
        .EXP_W  (EXP_W),
        .SLOT_W (SLOT_W),
        .ROW_W  (ROW_W)
    ) u_map (
        .slot      (seq_q.slot),
        .exp_len   (seq_q.exp_len),
        .rst_en    (map_rst_en),
        .rst_row   (map_rst_row),
        .rd_en     (map_rd_en),
        .rd_row    (map_rd_row),
        .last_slot (map_last)
    );

    rs_col_step #(
        .GROUP (GROUP),
        .COL_W (COL_W)
    ) u_col (
        .col      (seq_q.col),
        .col_last (col_last),
        .col_next (col_next)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.rst_p  = 1'b0;
        seq_d.adc_go = 1'b0;
        seq_d.pv     = 1'b0;
        seq_d.fdone  = 1'b0;
        end_slot     = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.exp_len = exp_safe;
                    seq_d.gain    = gain_code;
                    seq_d.slot    = '0;
                    seq_d.st      = ST_BEGIN;
                end
            end
            ST_BEGIN: begin
                if (map_rst_en) begin
                    seq_d.rst_p   = 1'b1;
                    seq_d.rst_row = map_rst_row;
                end
                if (map_rd_en) begin
                    seq_d.sel     = 1'b1;
                    seq_d.sel_row = map_rd_row;
                    seq_d.col     = '0;
                    seq_d.st      = ST_START;
                end else begin
                    seq_d.pad     = '0;
                    seq_d.st      = ST_PAD;
                end
            end
            ST_START: begin
                seq_d.adc_go = 1'b1;
                seq_d.st     = ST_WAIT;
            end
            ST_WAIT: begin
                if (adc_done) begin
                    seq_d.pv   = 1'b1;
                    seq_d.code = adc_code;
                    seq_d.prow = seq_q.sel_row;
                    seq_d.pcol = seq_q.col;
                    if (col_last) begin
                        seq_d.sel = 1'b0;
                        end_slot  = 1'b1;
                    end else begin
                        seq_d.col = col_next;
                        seq_d.st  = ST_START;
                    end
                end
            end
            ST_PAD: begin
                if (seq_q.pad == PAD_END) begin
                    end_slot = 1'b1;
                end else begin
                    seq_d.pad = seq_q.pad + PAD_W'(1);
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase

        if (end_slot) begin
            if (map_last) begin
                seq_d.st    = ST_IDLE;
                seq_d.fdone = 1'b1;
            end else begin
                seq_d.slot  = seq_q.slot + SLOT_W'(1);
                seq_d.st    = ST_BEGIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q    <= seq_d;
        end
    end

    assign row_rst     = seq_q.rst_p;
    assign row_rst_idx = seq_q.rst_row;
    assign row_sel     = seq_q.sel;
    assign row_sel_idx = seq_q.sel_row;
    assign col_idx     = seq_q.col;
    assign gain_out    = seq_q.gain;
    assign adc_start   = seq_q.adc_go;
    assign pix_valid   = seq_q.pv;
    assign pix_code    = seq_q.code;
    assign pix_row     = seq_q.prow;
    assign pix_col     = seq_q.pcol;
    assign frame_done  = seq_q.fdone;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && start) |=> ($stable(seq_q.exp_len) && $stable(seq_q.gain))); // R2

    AST_ADC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R6

    AST_ADC_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> row_sel); // R6

    AST_COL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT && !adc_done) |=> $stable(col_idx)); // R7

    AST_PIX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid); // R8

    AST_SEL_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel && $past(row_sel)) |-> $stable(row_sel_idx)); // R5

    AST_GAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && $past(seq_q.st) != ST_IDLE) |-> $stable(gain_out)); // R10

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (seq_q.st == ST_IDLE && !row_sel && pix_valid)); // R11

endmodule

// File: tb/rs_row_sequencer_test.sv
module rs_row_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS    = 4;
    localparam int GROUP   = 8;
    localparam int CODE_W  = 10;
    localparam int PAD_CYC = 3;
    localparam int EXP_W   = $clog2(ROWS + 1);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(GROUP);
    localparam int NVEC    = 6;

    localparam int VEC_RAW [NVEC] = '{0, 1, 2, 3, 4, 7};
    localparam int VEC_EXP [NVEC] = '{1, 1, 2, 3, 4, 4};
    localparam int VEC_GAIN[NVEC] = '{0, 1, 2, 3, 2, 1};
    localparam int VEC_LAT [NVEC] = '{0, 1, 3, 0, 20, 2};
    localparam int VEC_BUSY[NVEC] = '{0, 0, 1, 0, 0, 1};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [EXP_W-1:0]  exp_rows;
    logic [1:0]        gain_code;
    logic              adc_done;
    logic [CODE_W-1:0] adc_code;
    logic              row_rst;
    logic [ROW_W-1:0]  row_rst_idx;
    logic              row_sel;
    logic [ROW_W-1:0]  row_sel_idx;
    logic [COL_W-1:0]  col_idx;
    logic [1:0]        gain_out;
    logic              adc_start;
    logic              pix_valid;
    logic [CODE_W-1:0] pix_code;
    logic [ROW_W-1:0]  pix_row;
    logic [COL_W-1:0]  pix_col;
    logic              frame_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    bit mon_on = 0;

    int exp_cur, gain_cur, adc_lat, adc_n;
    int rst_expect, read_expect, conv_n, fd_cnt, cyc;
    int pad_prev_cyc;
    bit pad_prev_valid, sel_prev, done_prev;
    int col_prev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_row_sequencer #(
        .ROWS    (ROWS),
        .GROUP   (GROUP),
        .CODE_W  (CODE_W),
        .PAD_CYC (PAD_CYC)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .exp_rows    (exp_rows),
        .gain_code   (gain_code),
        .adc_done    (adc_done),
        .adc_code    (adc_code),
        .row_rst     (row_rst),
        .row_rst_idx (row_rst_idx),
        .row_sel     (row_sel),
        .row_sel_idx (row_sel_idx),
        .col_idx     (col_idx),
        .gain_out    (gain_out),
        .adc_start   (adc_start),
        .pix_valid   (pix_valid),
        .pix_code    (pix_code),
        .pix_row     (pix_row),
        .pix_col     (pix_col),
        .frame_done  (frame_done)
    );

    function automatic int code_of(input int n);
        return (n * 37 + 11) % (1 << CODE_W);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // converter model
    initial begin
        adc_done = 1'b0;
        adc_code = '0;
        forever begin
            @(negedge clk);
            if (rst_n && adc_start) begin
                int cv;
                cv = code_of(adc_n);
                adc_n++;
                repeat (adc_lat) @(negedge clk);
                adc_done = 1'b1;
                adc_code = CODE_W'(cv);
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    // output monitor, sampled one time unit after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            if (mon_on) begin
                if (row_rst) begin
                    chk(int'(row_rst_idx) == rst_expect, "R4 reset row", int'(row_rst_idx), rst_expect);
                    if (int'(row_rst_idx) >= exp_cur)
                        chk(row_sel && int'(row_sel_idx) == int'(row_rst_idx) - exp_cur,
                            "R4 read row beside reset", int'(row_sel_idx), int'(row_rst_idx) - exp_cur);
                    else
                        chk(!row_sel, "R4 no read in early slot", int'(row_sel), 0);
                    if (pad_prev_valid)
                        chk(cyc - pad_prev_cyc == PAD_CYC + 1, "R12 pad slot length",
                            cyc - pad_prev_cyc, PAD_CYC + 1);
                    pad_prev_valid = !row_sel;
                    pad_prev_cyc   = cyc;
                    rst_expect++;
                end
                if (row_sel && !sel_prev) begin
                    chk(int'(row_sel_idx) == read_expect, "R9 read order", int'(row_sel_idx), read_expect);
                    chk(conv_n == read_expect * GROUP, "R9 previous row complete", conv_n, read_expect * GROUP);
                    if (read_expect + exp_cur >= ROWS)
                        chk(!row_rst, "R4 no reset in tail slot", int'(row_rst), 0);
                    read_expect++;
                end
                if (row_sel && sel_prev) begin
                    if (int'(col_idx) != col_prev)
                        chk(done_prev, "R7 column moved without done", int'(done_prev), 1);
                end
                if (adc_start) begin
                    chk(row_sel, "R6 start outside select", int'(row_sel), 1);
                    chk(int'(col_idx) == conv_n % GROUP, "R6 column order", int'(col_idx), conv_n % GROUP);
                    chk(int'(gain_out) == gain_cur, "R10 gain held", int'(gain_out), gain_cur);
                end
                if (pix_valid) begin
                    chk(int'(pix_row) == conv_n / GROUP && int'(pix_col) == conv_n % GROUP,
                        "R8 pixel tag", int'(pix_row) * GROUP + int'(pix_col), conv_n);
                    chk(int'(pix_code) == code_of(conv_n), "R8 pixel code", int'(pix_code), code_of(conv_n));
                    conv_n++;
                end
                if (frame_done) begin
                    chk(conv_n == ROWS * GROUP, "R11 done after last pixel", conv_n, ROWS * GROUP);
                    fd_cnt++;
                end
            end
            sel_prev  = row_sel;
            done_prev = adc_done;
            col_prev  = int'(col_idx);
        end
    end

    task automatic run_frame(input int raw, input int ex, input int g, input int lat, input int busy);
        @(negedge clk);
        exp_cur        = ex;
        gain_cur       = g;
        adc_lat        = lat;
        adc_n          = 0;
        rst_expect     = 0;
        read_expect    = 0;
        conv_n         = 0;
        fd_cnt         = 0;
        pad_prev_valid = 0;
        exp_rows       = EXP_W'(raw);
        gain_code      = 2'(g);
        start          = 1'b1;
        @(negedge clk);
        start          = 1'b0;
        if (busy != 0) begin
            repeat (25) @(negedge clk);
            start     = 1'b1;
            gain_code = ~2'(g);
            exp_rows  = EXP_W'(1);
            @(negedge clk);
            start     = 1'b0;
            #2;
            chk(int'(gain_out) == g, "R2 busy start ignored", int'(gain_out), g);
        end
        while (fd_cnt == 0) @(negedge clk);
        repeat (PAD_CYC + 6) @(negedge clk);
        #2;
        chk(fd_cnt == 1, "R11 single done", fd_cnt, 1);
        chk(rst_expect == ROWS, "R4 resets per frame", rst_expect, ROWS);
        chk(read_expect == ROWS, "R9 rows per frame", read_expect, ROWS);
        chk(conv_n == ROWS * GROUP, "R9 pixels per frame", conv_n, ROWS * GROUP);
        chk(int'(gain_out) == g, "R10 gain code", int'(gain_out), g);
        chk(!row_sel && !adc_start, "R11 idle after done", int'(row_sel), 0);
    endtask

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        exp_rows  = '0;
        gain_code = '0;
        adc_lat   = 0;
        exp_cur   = 1;
        gain_cur  = 0;
        repeat (3) @(negedge clk);
        #2;
        chk(!row_rst && !row_sel && !adc_start && !pix_valid && !frame_done,
            "R1 strobes in reset", int'(row_sel), 0);
        chk(col_idx == '0 && gain_out == '0, "R1 fields in reset", int'(gain_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!row_rst && !row_sel && !adc_start && !pix_valid && !frame_done,
            "R1 strobes after release", int'(row_rst), 0);
        mon_on = 1;

        // vector table walk: exposure clamp R3, gain R10, latency R7
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC_RAW[i], VEC_EXP[i], VEC_GAIN[i], VEC_LAT[i], VEC_BUSY[i]);
        end

        // directed: start while idle right after a frame is accepted again (R2)
        run_frame(2, 2, 3, 0, 0);

        // directed: reset mid-frame returns outputs to the reset state (R1)
        @(negedge clk);
        exp_rows  = EXP_W'(1);
        gain_code = 2'd2;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        mon_on    = 0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #2;
        chk(!row_sel && !adc_start && col_idx == '0 && gain_out == '0,
            "R1 reset mid-frame", int'(gain_out), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

endmodule